// File: doc/BRIEF.md
# Raster Test Pattern Stream Source

This block produces complete raster frames of 24-bit RGB pixels on a streaming video master port. It is used to feed a frame-buffer writer or a downstream pixel path with content that can be predicted. Each pixel's colour is derived from its row and column, so any receiver can check every beat without stored reference images. Two sideband flags travel with the data. One marks the first pixel of a frame. The other marks the last pixel of each line.

A one-cycle start request launches a run of a parameterized number of back-to-back frames. The source raises its valid flag on its own, without waiting for ready. A beat leaves the port only in a cycle where valid and ready are both high. While the receiver holds ready low, the offered beat stays frozen. A busy flag covers the run. A one-cycle done pulse follows acceptance of the final pixel.

Top module: `vid_pattern_src`

## Requirements
- R1: A synchronous active-high reset clears valid, busy and done, and returns the raster position to row 0, column 0, frame 0.
- R2: A start pulse seen while idle makes busy and valid high from the next cycle on.
- R3: The data word of the pixel at row r and column c is {r[7:0], c[7:0], r[7:0]^c[7:0]}, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: A beat is consumed only in a cycle where valid and ready are both high. While valid is high and ready is low, valid stays high and data, start-of-frame and end-of-line hold their values.
- R5: Valid rises and stays high whether ready is high or low. It never waits for ready.
- R6: The start-of-frame flag is high on the pixel at row 0, column 0 of every frame and low on all other beats.
- R7: The end-of-line flag is high on the beat at column H_PIXELS-1 of every line and low on all other beats.
- R8: Pixels go out column by column within a line and line by line within a frame, using H_PIXELS columns and V_LINES lines. A run holds FRAMES frames, and the default raster is 1920 x 1080.
- R9: A start pulse that arrives while busy is high has no effect on the pixel sequence or on the length of the run.
- R10: After the final beat of the final frame is accepted, valid and busy go low in the next cycle and done is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a run when idle |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse after the last beat of the run |
| tdata_o | output | 24 | Pixel word: red, green, blue |
| tvalid_o | output | 1 | Beat offered |
| tready_i | input | 1 | Receiver accepts the beat |
| tuser_o | output | 1 | Start-of-frame flag |
| tlast_o | output | 1 | End-of-line flag |

## Verification
The bound checker looks at every cycle. It checks that a stalled beat stays frozen, that every run opens on a start-of-frame beat, that the end-of-line flag sits at the column position counted from accepted beats, and that done is a single idle-state pulse. Other properties depend on the full history of a run: the exact pixel values, the line and frame ordering, the count of frames, and the fact that a start pulse during a run is ignored. Only the bench's reference model can show these. It replays them under steady, alternating, pseudo-random and fully blocked ready patterns.

// File: rtl/vps_pkg.sv
package vps_pkg;

    localparam int PIX_W = 24;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic logic [PIX_W-1:0] pack_pixel(input logic [7:0] r8, input logic [7:0] c8);
        return {r8, c8, r8 ^ c8};
    endfunction

endpackage

// File: rtl/vps_raster_ctr.sv
module vps_raster_ctr #(
    parameter int H_PIXELS = 1920,
    parameter int V_LINES  = 1080,
    parameter int FRAMES   = 1,
    localparam int CW = (H_PIXELS > 1) ? $clog2(H_PIXELS) : 1,
    localparam int RW = (V_LINES  > 1) ? $clog2(V_LINES)  : 1,
    localparam int FW = (FRAMES   > 1) ? $clog2(FRAMES)   : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic          line_end,
    output logic          frame_first,
    output logic          final_beat
);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic [FW-1:0] frm;
    } pos_t;

    pos_t pos_d, pos_q;

    logic last_col, last_row, last_frm;

    always_comb begin
        last_col = (pos_q.col == CW'(H_PIXELS - 1));
        last_row = (pos_q.row == RW'(V_LINES - 1));
        last_frm = (pos_q.frm == FW'(FRAMES - 1));
        pos_d    = pos_q;
        if (step) begin
            if (!last_col) begin
                pos_d.col = pos_q.col + 1'b1;
            end else begin
                pos_d.col = '0;
                if (!last_row) begin
                    pos_d.row = pos_q.row + 1'b1;
                end else begin
                    pos_d.row = '0;
                    if (!last_frm) begin
                        pos_d.frm = pos_q.frm + 1'b1;
                    end else begin
                        pos_d.frm = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign col         = pos_q.col;
    assign row         = pos_q.row;
    assign line_end    = last_col;
    assign frame_first = (pos_q.col == '0) && (pos_q.row == '0);
    assign final_beat  = last_col && last_row && last_frm;

endmodule

// File: rtl/vps_pixel_fmt.sv
module vps_pixel_fmt
    import vps_pkg::*;
#(
    parameter int CW = 11,
    parameter int RW = 11
) (
    input  logic [CW-1:0]    col,
    input  logic [RW-1:0]    row,
    output logic [PIX_W-1:0] pixel
);

    logic [31:0] col_ext, row_ext;

    always_comb begin
        col_ext = 32'(col);
        row_ext = 32'(row);
        pixel   = pack_pixel(row_ext[7:0], col_ext[7:0]);
    end

endmodule

// File: rtl/vps_ctrl.sv
module vps_ctrl
    import vps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic accept,
    input  logic final_beat,
    output logic run,
    output logic done
);

    typedef struct packed {
        phase_e ph;
        logic   done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.ph = PH_RUN;
                end
            end
            PH_RUN: begin
                if (accept && final_beat) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{ph: PH_IDLE, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run  = (ctl_q.ph == PH_RUN);
    assign done = ctl_q.done;

endmodule

// File: rtl/vid_pattern_src.sv
module vid_pattern_src
    import vps_pkg::*;
#(
    parameter int H_PIXELS = 1920,
    parameter int V_LINES  = 1080,
    parameter int FRAMES   = 1,
    localparam int CW = (H_PIXELS > 1) ? $clog2(H_PIXELS) : 1,
    localparam int RW = (V_LINES  > 1) ? $clog2(V_LINES)  : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [PIX_W-1:0] tdata_o,
    output logic             tvalid_o,
    input  logic             tready_i,
    output logic             tuser_o,
    output logic             tlast_o
);

    logic          run, accept;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          line_end, frame_first, final_beat;

    assign accept = run && tready_i;

    vps_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .accept     (accept),
        .final_beat (final_beat),
        .run        (run),
        .done       (done_o)
    );

    vps_raster_ctr #(
        .H_PIXELS (H_PIXELS),
        .V_LINES  (V_LINES),
        .FRAMES   (FRAMES)
    ) u_raster (
        .clk         (clk),
        .rst         (rst),
        .step        (accept),
        .col         (col),
        .row         (row),
        .line_end    (line_end),
        .frame_first (frame_first),
        .final_beat  (final_beat)
    );

    vps_pixel_fmt #(
        .CW (CW),
        .RW (RW)
    ) u_fmt (
        .col   (col),
        .row   (row),
        .pixel (tdata_o)
    );

    assign tvalid_o = run;
    assign busy_o   = run;
    assign tuser_o  = run && frame_first;
    assign tlast_o  = run && line_end;

endmodule

// File: rtl/vps_checker.sv
module vps_checker #(
    parameter int H_PIXELS = 1920
) (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [23:0] tdata_o,
    input logic        tvalid_o,
    input logic        tready_i,
    input logic        tuser_o,
    input logic        tlast_o
);

    int unsigned seen_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_col <= 0;
        end else if (tvalid_o && tready_i) begin
            seen_col <= (seen_col == H_PIXELS - 1) ? 0 : seen_col + 1;
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        tvalid_o && !tready_i |=> tvalid_o && $stable(tdata_o) && $stable(tuser_o) && $stable(tlast_o));

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        !busy_o && start_i |=> busy_o && tvalid_o);

    p_open_sof_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tvalid_o) |-> tuser_o);

    p_eol_pos_r7: assert property (@(posedge clk) disable iff (rst)
        tvalid_o |-> (tlast_o == (seen_col == H_PIXELS - 1)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !tvalid_o && !busy_o);

endmodule

bind vid_pattern_src vps_checker #(.H_PIXELS(H_PIXELS)) i_vps_checker (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .tdata_o  (tdata_o),
    .tvalid_o (tvalid_o),
    .tready_i (tready_i),
    .tuser_o  (tuser_o),
    .tlast_o  (tlast_o)
);

// File: tb/test_vid_pattern_src.sv
`timescale 1ns/1ps
module test_vid_pattern_src;

    localparam int W = 8;
    localparam int H = 4;
    localparam int F = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        tready_i = 1'b0;
    logic        busy_o, done_o, tvalid_o, tuser_o, tlast_o;
    logic [23:0] tdata_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state
    int  m_row = 0, m_col = 0, m_frm = 0;
    bit  m_busy = 0, m_done = 0;
    int  beats = 0, runs_done = 0;

    always #10 clk = ~clk;

    vid_pattern_src #(.H_PIXELS(W), .V_LINES(H), .FRAMES(F)) i_vid_pattern_src (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .tdata_o  (tdata_o),
        .tvalid_o (tvalid_o),
        .tready_i (tready_i),
        .tuser_o  (tuser_o),
        .tlast_o  (tlast_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural model: advances on the clock edge from the inputs only
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_row = 0; m_col = 0; m_frm = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start_i) m_busy = 1;
            end else if (tready_i) begin
                beats++;
                if (m_col < W - 1) m_col++;
                else begin
                    m_col = 0;
                    if (m_row < H - 1) m_row++;
                    else begin
                        m_row = 0;
                        if (m_frm < F - 1) m_frm++;
                        else begin
                            m_frm = 0; m_busy = 0; m_done = 1; runs_done++;
                        end
                    end
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2/R5 valid", 32'(tvalid_o), 32'(m_busy));
            check("R2 busy", 32'(busy_o), 32'(m_busy));
            check("R10 done", 32'(done_o), 32'(m_done));
            check("R6 sof", 32'(tuser_o), 32'(m_busy && m_row == 0 && m_col == 0));
            check("R7 eol", 32'(tlast_o), 32'(m_busy && m_col == W - 1));
            if (m_busy) begin
                logic [7:0] r8, c8;
                r8 = 8'(m_row);
                c8 = 8'(m_col);
                check("R3/R4/R8 data", 32'(tdata_o), 32'({r8, c8, r8 ^ c8}));
            end
        end
    end

    // pseudo-random ready source
    logic [15:0] lfsr = 16'hACE1;

    task automatic wait_run(input int mode, input bit poke_start);
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: tready_i = 1'b1;
                1: tready_i = n[0];
                2: tready_i = lfsr[0];
                default: tready_i = (n > 12);
            endcase
            start_i = poke_start && (n % 7 == 3); // R9: pulses mid-run
            if (done_o) break;
            if (n > 5000) break;
        end
        start_i = 1'b0;
    endtask

    task automatic launch(input bit ready_during_start);
        @(negedge clk);
        tready_i = ready_during_start;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(tvalid_o), 0);
        check("R1 busy", 32'(busy_o), 0);
        check("R1 done", 32'(done_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle valid", 32'(tvalid_o), 0);

        // R5: start with ready low, valid must still rise
        launch(1'b0);
        check("R5 valid without ready", 32'(tvalid_o), 1);
        check("R1 first beat sof", 32'(tuser_o), 1);
        wait_run(3, 1'b0);
        wait_run(0, 1'b0);

        launch(1'b1);
        wait_run(1, 1'b1);
        launch(1'b0);
        wait_run(2, 1'b1);
        launch(1'b1);
        wait_run(0, 1'b1);

        @(negedge clk);
        check("R10 idle after done", 32'(tvalid_o), 0);
        check("R8/R9 run count", 32'(runs_done), 4);
        check("R8/R9 beat count", 32'(beats), 32'(4 * W * H * F));

        // R1: reset mid-run
        launch(1'b1);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 32'(tvalid_o), 0);
        launch(1'b1);
        check("R1 restart sof", 32'(tuser_o), 1);
        check("R1 restart data", 32'(tdata_o), 0);
        wait_run(0, 1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule